// File: doc/BRIEF.md
# Atomic-Section Write Signature Filter

This block keeps, for one core, a compact record of the word addresses written inside lock-protected (atomic) sections. The record is a 256-bit Bloom-style bit vector. Every atomic store hashes its word address to two bit positions and sets both bits. When an atomic load arrives, the block tests those two positions for its own address. If both are set, the cached copy of that word may be stale, and the load must self-invalidate that copy before it completes.

Two shortcuts skip the test. A load to a word the cache already holds in the Registered state never needs to self-invalidate. A word that has already been read atomically carries a per-word touched flag, and later loads of that word skip the test until the next self-invalidation. When the core performs a self-invalidation, it pulses a clear input, which empties both the signature and the touched flags.

The whole signature is always visible on a parallel export bus, so it can ride on the lock hand-off message. An incoming signature from the previous lock holder is OR-merged into the local one in a single cycle.

Top module: `atomic_sig_filter`

## Requirements
- R1: After synchronous reset, every bit of `sig_out` is 0 and every touched flag is clear. An atomic, non-registered load issued right after reset therefore reports `ld_inval` = 0.
- R2: A store with `st_valid`=1 and `st_atomic`=1 sets two bits of the signature. Word address `a` is 16 bits wide. The first bit is `a[7:0] ^ a[15:8]`. The second bit is `r[7:0] ^ r[15:8] ^ 8'hA5`, where `r` is `a` rotated left by 5 bits. Both bits are set from the clock edge that samples the store.
- R3: A store with `st_atomic`=0 leaves the signature unchanged.
- R4: Each load sampled with `ld_valid`=1 produces `ld_resp_valid`=1 one cycle later. In that same cycle, `ld_inval` is 1 exactly when all of the following hold: the load is atomic, it is not registered, its touched flag is clear, and both of its hashed bits are set.
- R5: The signature never loses a bit except through clear. So an atomic, non-registered, untouched load to any previously inserted address always reports `ld_inval`=1, with no false negatives.
- R6: A load with `ld_registered`=1 always reports `ld_inval`=0.
- R7: Any atomic load sets the touched flag at index `ld_addr[5:0]`, including a registered one. A later atomic load with the same index reports `ld_inval`=0 until the next clear.
- R8: A non-atomic load reports `ld_inval`=0 and does not set a touched flag.
- R9: The `clear` input empties the signature and all touched flags at the clock edge that samples it. Clear takes priority over a store, an import or a touched-flag update sampled in the same cycle.
- R10: `sig_out` always equals the stored signature, bit for bit.
- R11: `imp_valid`=1 ORs `imp_sig` into the signature in one cycle. The import combines with an atomic store sampled in the same cycle.
- R12: A load evaluates the signature and touched flags as they stood before the edge that samples it. A store, import or clear in that same cycle does not affect that load's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store strobe |
| st_atomic | input | 1 | Store targets an atomic region |
| st_addr | input | 16 | Store word address |
| ld_valid | input | 1 | Load strobe |
| ld_atomic | input | 1 | Load targets an atomic region |
| ld_registered | input | 1 | Cached word is in the Registered state |
| ld_addr | input | 16 | Load word address |
| ld_resp_valid | output | 1 | Load result valid, one cycle after the load |
| ld_inval | output | 1 | Cached copy must self-invalidate |
| clear | input | 1 | Self-invalidation performed; empty the filter |
| sig_out | output | 256 | Current signature for export |
| imp_valid | input | 1 | Merge an incoming signature |
| imp_sig | input | 256 | Incoming signature |

## Verification
Signature updates from stores, imports and clear appear on `sig_out` after exactly one clock edge. Load results appear on `ld_resp_valid`/`ld_inval` in the cycle after the load is sampled. The bench drives every stimulus on a falling edge and checks at the next falling edge, which is one rising edge later, where both kinds of result are due. The bench's model evaluates a load against the state that existed before that edge, which matches the design's one-cycle registered response and the same-cycle ordering in R12.

// File: rtl/sigf_pkg.sv
package sigf_pkg;

    localparam int SIG_BITS    = 256;
    localparam int IDX_W       = $clog2(SIG_BITS);
    localparam int ADDR_W      = 16;
    localparam int FOLD_CHUNKS = ADDR_W / IDX_W;
    localparam int NUM_HASH    = 2;
    localparam int HASH_ROT    = 5;
    localparam logic [IDX_W-1:0] HASH_SALT = 8'hA5;
    localparam int TOUCH_WORDS = 64;
    localparam int TOUCH_IDX_W = $clog2(TOUCH_WORDS);

    typedef logic [ADDR_W-1:0]   waddr_t;
    typedef logic [IDX_W-1:0]    sig_idx_t;
    typedef logic [SIG_BITS-1:0] sig_vec_t;

    typedef struct packed {
        logic   valid;
        logic   atomic;
        waddr_t addr;
    } st_req_t;

    typedef struct packed {
        logic   valid;
        logic   atomic;
        logic   registered;
        waddr_t addr;
    } ld_req_t;

    typedef enum logic [1:0] {
        LD_NONE = 2'd0,
        LD_SKIP = 2'd1,
        LD_MISS = 2'd2,
        LD_HIT  = 2'd3
    } ld_class_t;

    function automatic waddr_t rotl(input waddr_t a, input int unsigned n);
        waddr_t r;
        r = a;
        for (int unsigned i = 0; i < n; i++) begin
            r = {r[ADDR_W-2:0], r[ADDR_W-1]};
        end
        return r;
    endfunction

    function automatic sig_idx_t xor_fold(input waddr_t a);
        sig_idx_t acc;
        acc = '0;
        for (int i = 0; i < FOLD_CHUNKS; i++) begin
            acc = acc ^ a[i*IDX_W +: IDX_W];
        end
        return acc;
    endfunction

    function automatic sig_idx_t sig_hash(input waddr_t a, input int unsigned k);
        sig_idx_t h;
        h = xor_fold(rotl(a, k * HASH_ROT));
        if (k != 0) begin
            h = h ^ HASH_SALT;
        end
        return h;
    endfunction

endpackage

// File: rtl/sigf_hash.sv
module sigf_hash
    import sigf_pkg::*;
#(
    parameter int unsigned K = 0
) (
    input  waddr_t   addr,
    output sig_idx_t idx
);
    assign idx = sig_hash(addr, K);
endmodule

// File: rtl/sigf_bitvec.sv
module sigf_bitvec
    import sigf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     set_en,
    input  sig_vec_t set_mask,
    input  logic     merge_en,
    input  sig_vec_t merge_vec,
    output sig_vec_t bits
);
    sig_vec_t bits_q;
    sig_vec_t bits_d;

    always_comb begin
        bits_d = bits_q;
        if (set_en) begin
            bits_d = bits_d | set_mask;
        end
        if (merge_en) begin
            bits_d = bits_d | merge_vec;
        end
        if (clr) begin
            bits_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
        end else begin
            bits_q <= bits_d;
        end
    end

    assign bits = bits_q;
endmodule

// File: rtl/sigf_touch.sv
module sigf_touch
    import sigf_pkg::*;
#(
    parameter int WORDS = TOUCH_WORDS,
    localparam int IW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          mark_en,
    input  logic [IW-1:0] mark_idx,
    input  logic [IW-1:0] rd_idx,
    output logic          rd_touched
);
    logic [WORDS-1:0] flags_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            flags_q <= '0;
        end else if (mark_en) begin
            flags_q[mark_idx] <= 1'b1;
        end
    end

    assign rd_touched = flags_q[rd_idx];
endmodule

// File: rtl/atomic_sig_filter.sv
module atomic_sig_filter
    import sigf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                st_valid,
    input  logic                st_atomic,
    input  logic [ADDR_W-1:0]   st_addr,
    input  logic                ld_valid,
    input  logic                ld_atomic,
    input  logic                ld_registered,
    input  logic [ADDR_W-1:0]   ld_addr,
    output logic                ld_resp_valid,
    output logic                ld_inval,
    input  logic                clear,
    output logic [SIG_BITS-1:0] sig_out,
    input  logic                imp_valid,
    input  logic [SIG_BITS-1:0] imp_sig
);
    st_req_t   st_req;
    ld_req_t   ld_req;
    sig_idx_t  st_idx [NUM_HASH];
    sig_idx_t  ld_idx [NUM_HASH];
    sig_vec_t  st_mask;
    sig_vec_t  bits;
    logic      all_set;
    logic      touched;
    ld_class_t ld_cls;
    logic      resp_valid_q;
    logic      inval_q;

    assign st_req = '{valid: st_valid, atomic: st_atomic, addr: st_addr};
    assign ld_req = '{valid: ld_valid, atomic: ld_atomic,
                      registered: ld_registered, addr: ld_addr};

    for (genvar k = 0; k < NUM_HASH; k++) begin : g_hash
        sigf_hash #(.K(k)) i_st_hash (.addr(st_req.addr), .idx(st_idx[k]));
        sigf_hash #(.K(k)) i_ld_hash (.addr(ld_req.addr), .idx(ld_idx[k]));
    end

    always_comb begin
        st_mask = '0;
        for (int k = 0; k < NUM_HASH; k++) begin
            st_mask[st_idx[k]] = 1'b1;
        end
    end

    sigf_bitvec i_bits (
        .clk       (clk),
        .rst       (rst),
        .clr       (clear),
        .set_en    (st_req.valid && st_req.atomic),
        .set_mask  (st_mask),
        .merge_en  (imp_valid),
        .merge_vec (imp_sig),
        .bits      (bits)
    );

    sigf_touch #(.WORDS(TOUCH_WORDS)) i_touch (
        .clk        (clk),
        .rst        (rst),
        .clr        (clear),
        .mark_en    (ld_req.valid && ld_req.atomic),
        .mark_idx   (ld_req.addr[TOUCH_IDX_W-1:0]),
        .rd_idx     (ld_req.addr[TOUCH_IDX_W-1:0]),
        .rd_touched (touched)
    );

    always_comb begin
        all_set = 1'b1;
        for (int k = 0; k < NUM_HASH; k++) begin
            all_set = all_set & bits[ld_idx[k]];
        end
    end

    always_comb begin
        if (!ld_req.valid) begin
            ld_cls = LD_NONE;
        end else if (!ld_req.atomic || ld_req.registered || touched) begin
            ld_cls = LD_SKIP;
        end else if (all_set) begin
            ld_cls = LD_HIT;
        end else begin
            ld_cls = LD_MISS;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid_q <= 1'b0;
            inval_q      <= 1'b0;
        end else begin
            resp_valid_q <= (ld_cls != LD_NONE);
            inval_q      <= (ld_cls == LD_HIT);
        end
    end

    assign ld_resp_valid = resp_valid_q;
    assign ld_inval      = inval_q;
    assign sig_out       = bits;
endmodule

// File: rtl/sigf_checker.sv
module sigf_checker
    import sigf_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                st_valid,
    input logic                st_atomic,
    input logic [ADDR_W-1:0]   st_addr,
    input logic                ld_valid,
    input logic                ld_registered,
    input logic                ld_resp_valid,
    input logic                ld_inval,
    input logic                clear,
    input logic [SIG_BITS-1:0] sig_out,
    input logic                imp_valid,
    input logic [SIG_BITS-1:0] imp_sig
);
    AST_RESET_EMPTY: assert property (@(posedge clk) rst |=> (sig_out == '0)); // R1

    AST_INSERT_SETS: assert property (@(posedge clk) disable iff (rst)
        (st_valid && st_atomic && !clear) |=>
        (sig_out[sig_hash($past(st_addr), 0)] && sig_out[sig_hash($past(st_addr), 1)])); // R2

    AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!clear && !imp_valid && !(st_valid && st_atomic)) |=> $stable(sig_out)); // R3

    AST_RESP_TIMING: assert property (@(posedge clk) disable iff (rst)
        ld_valid |=> ld_resp_valid); // R4

    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (rst)
        !ld_valid |=> !ld_resp_valid); // R4

    AST_BITS_KEPT: assert property (@(posedge clk) disable iff (rst)
        !clear |=> ((sig_out & $past(sig_out)) == $past(sig_out))); // R5

    AST_REGISTERED_NO_INVAL: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && ld_registered) |=> !ld_inval); // R6

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clear |=> (sig_out == '0)); // R9

    AST_IMPORT_MERGED: assert property (@(posedge clk) disable iff (rst)
        (imp_valid && !clear) |=> ((sig_out & $past(imp_sig)) == $past(imp_sig))); // R11
endmodule

bind atomic_sig_filter sigf_checker i_sigf_checker (.*);

// File: tb/test_atomic_sig_filter.sv
`timescale 1ns/1ps
module test_atomic_sig_filter;

    logic         clk = 1'b0;
    logic         rst;
    logic         st_valid, st_atomic;
    logic [15:0]  st_addr;
    logic         ld_valid, ld_atomic, ld_registered;
    logic [15:0]  ld_addr;
    logic         ld_resp_valid, ld_inval;
    logic         clear;
    logic [255:0] sig_out;
    logic         imp_valid;
    logic [255:0] imp_sig;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [255:0] m_sig;
    logic [63:0]  m_touch;
    logic [15:0]  ins_list [48];

    always #2.5 clk = ~clk;

    atomic_sig_filter i_atomic_sig_filter (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_atomic(st_atomic), .st_addr(st_addr),
        .ld_valid(ld_valid), .ld_atomic(ld_atomic), .ld_registered(ld_registered),
        .ld_addr(ld_addr), .ld_resp_valid(ld_resp_valid), .ld_inval(ld_inval),
        .clear(clear), .sig_out(sig_out), .imp_valid(imp_valid), .imp_sig(imp_sig)
    );

    function automatic logic [7:0] h0(input logic [15:0] a);
        return a[7:0] ^ a[15:8];
    endfunction

    function automatic logic [7:0] h1(input logic [15:0] a);
        logic [15:0] r;
        r = {a[10:0], a[15:11]};
        return r[7:0] ^ r[15:8] ^ 8'hA5;
    endfunction

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One cycle of stimulus: drive after a falling edge, check at the next one.
    task automatic step(input string req,
                        input logic sv, input logic sa, input logic [15:0] saddr,
                        input logic lv, input logic la, input logic lr, input logic [15:0] laddr,
                        input logic clr, input logic iv, input logic [255:0] ivec);
        logic exp_inval;
        logic [255:0] nsig;
        st_valid = sv; st_atomic = sa; st_addr = saddr;
        ld_valid = lv; ld_atomic = la; ld_registered = lr; ld_addr = laddr;
        clear = clr; imp_valid = iv; imp_sig = ivec;
        exp_inval = lv && la && !lr && !m_touch[laddr[5:0]]
                    && m_sig[h0(laddr)] && m_sig[h1(laddr)];
        nsig = m_sig;
        if (sv && sa) begin
            nsig[h0(saddr)] = 1'b1;
            nsig[h1(saddr)] = 1'b1;
        end
        if (iv) nsig = nsig | ivec;
        if (clr) begin
            nsig = '0;
            m_touch = '0;
        end else if (lv && la) begin
            m_touch[laddr[5:0]] = 1'b1;
        end
        m_sig = nsig;
        @(negedge clk);
        st_valid = 0; st_atomic = 0; ld_valid = 0; ld_atomic = 0; ld_registered = 0;
        clear = 0; imp_valid = 0; imp_sig = '0;
        chk({req, " sig"}, sig_out, m_sig);
        if (lv) begin
            chk({req, " resp_valid"}, 256'(ld_resp_valid), 256'(1));
            chk({req, " inval"}, 256'(ld_inval), 256'(exp_inval));
        end
    endtask

    task automatic store(input string req, input logic atomic, input logic [15:0] a);
        step(req, 1, atomic, a, 0, 0, 0, 16'h0, 0, 0, '0);
    endtask

    task automatic load(input string req, input logic atomic, input logic regd, input logic [15:0] a);
        step(req, 0, 0, 16'h0, 1, atomic, regd, a, 0, 0, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [255:0] ivec;
        logic [15:0]  a;
        rst = 1; st_valid = 0; st_atomic = 0; st_addr = '0;
        ld_valid = 0; ld_atomic = 0; ld_registered = 0; ld_addr = '0;
        clear = 0; imp_valid = 0; imp_sig = '0;
        m_sig = '0; m_touch = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1: empty after reset, and an atomic load sees no hit
        chk("R1 reset sig", sig_out, '0);
        chk("R1 reset resp", 256'(ld_resp_valid), 256'(0));
        load("R1 load after reset", 1, 0, 16'h1234);

        // R3: ordinary stores are ignored
        for (int i = 0; i < 16; i++) store("R3 ordinary store", 0, 16'($urandom));
        chk("R3 sig still empty", sig_out, '0);

        // R2: exact two-bit insertion for a known address
        store("R2 first insert", 1, 16'hBEEF);
        chk("R2 bit h0", 256'(sig_out[h0(16'hBEEF)]), 256'(1));
        chk("R2 bit h1", 256'(sig_out[h1(16'hBEEF)]), 256'(1));
        chk("R2 popcount", 256'($countones(sig_out)), 256'((h0(16'hBEEF) == h1(16'hBEEF)) ? 1 : 2));

        // R2 / R10: random atomic stream, sig_out tracked every cycle
        for (int i = 0; i < 48; i++) begin
            ins_list[i] = 16'($urandom);
            store("R2 R10 atomic insert", 1, ins_list[i]);
        end

        // R5 / R6 / R7 / R8: query every inserted address
        for (int i = 0; i < 48; i++) begin
            if (i % 4 == 0) begin
                load("R6 registered load", 1, 1, ins_list[i]);
            end else begin
                load("R8 non-atomic load", 0, 0, ins_list[i]);
                load("R5 atomic query", 1, 0, ins_list[i]);
            end
            load("R7 repeated atomic load", 1, 0, ins_list[i]);
        end

        // R4: sweep of arbitrary addresses against the model
        for (int i = 0; i < 256; i++) begin
            load("R4 sweep", 1, (i % 7 == 0), {8'(i * 37), 8'(i)});
        end

        // R9: clear empties filter and touched flags
        step("R9 clear", 0, 0, 16'h0, 0, 0, 0, 16'h0, 1, 0, '0);
        chk("R9 sig empty", sig_out, '0);
        store("R9 reinsert", 1, ins_list[1]);
        load("R9 touched flag cleared", 1, 0, ins_list[1]);
        step("R9 clear beats store/import", 1, 1, 16'h4242, 0, 0, 0, 16'h0, 1, 1, {8{32'hFFFF0000}});
        chk("R9 sig after priority clear", sig_out, '0);

        // R12: load sees pre-edge state while a store to the same word lands
        step("R12 same-cycle store+load", 1, 1, 16'h7777, 1, 1, 0, 16'h7777, 0, 0, '0);
        load("R12 next load sees touched", 1, 0, 16'h7777);
        step("R12 load with clear", 0, 0, 16'h0, 1, 1, 0, 16'h0A0A, 1, 0, '0);

        // R11: imports, alone and combined with a store
        for (int i = 0; i < 8; i++) begin
            ivec = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            ivec = ivec & {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            a = 16'($urandom);
            step("R11 import", (i % 2 == 1), 1, a, 0, 0, 0, 16'h0, 0, 1, ivec);
        end
        for (int i = 0; i < 32; i++) begin
            a = 16'($urandom);
            load("R4 R11 query after import", 1, 0, a);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule